// File: doc/BRIEF.md
# Platform Control and Status Register Block

This block is the small control and status register file of a development-board platform. It sits on a simple request/response bus. A request carries a valid strobe, a write flag, an address, write data and an access size in bytes. Every request is answered exactly one clock later. The block claims a 4 KiB window, but it decodes only the low 16 address bits, so higher address bits are don't-care.

It serves nineteen 32-bit words at offsets 0x00 through 0x48:
- **Fixed words.** Several words report fixed build information.
- **Packed words.** Some words pack the platform's static configuration inputs into fields: the reference clock in MHz and the installed memory in GiB.
- **Reset request.** One word accepts a software reset request and turns it into a single-cycle system reset pulse.

Accesses that are not exactly 4 bytes wide are rejected. An access to an offset that holds no word is answered with zero and flagged for one cycle.

Top module: `plat_regs_top`

## Requirements
- R1: While `rst_n` is low, `rsp_valid`, `rsp_rdata`, `sys_reset_pulse` and `unimpl_flag` are all zero. A reset request presented during reset produces no pulse.
- R2: Every request with `req_valid` high is answered with `rsp_valid` high in the next cycle. A read returns its data in `rsp_rdata` in that same cycle. A write returns `rsp_rdata` = 0.
- R3: An access whose `req_size` is not 4 reads as 0 and has no effect when written. A rejected access to a soft-reset word gives no pulse, and a rejected access to an empty offset raises no `unimpl_flag`.
- R4: The ID word (0x00) and the two revision words (0x04, 0x08) read as 0. The other listed words without content also read as 0: 0x0C, 0x10, 0x18, 0x1C, 0x20 to 0x2C, and 0x3C to 0x48.
- R5: The memory status word at 0x14 reads 0x0000_0005, that is, locked in bit 0 and calibrated in bit 2.
- R6: The clock divider word at 0x30 reads as follows: bits [31:24] = 1, bits [23:16] = 1, bits [15:8] = `cfg_ref_mhz`, bits [7:0] = 1.
- R7: The feature word at 0x34 reads 0x0000_000E: the three link-enable bits 1, 2 and 3 are set, and bit 0 is clear.
- R8: The memory configuration word at 0x38 reads bits [15:4] = 0xFFF and bits [3:0] = `cfg_mem_gib[3:0]`, with the remaining bits 0. The output `cfg_error` is high, combinationally, exactly when `cfg_mem_gib` exceeds 15.
- R9: Writes to the read-only words 0x00, 0x04, 0x08, 0x14, 0x18, 0x30, 0x34 and 0x38 are ignored. A later read of such a word returns its unchanged value.
- R10: A 4-byte write to 0x10 with bit 4 of `req_wdata` set drives `sys_reset_pulse` high for exactly the next cycle. The same write with bit 4 clear gives no pulse.
- R11: `sys_reset_pulse` is never high in two consecutive cycles. A reset write presented while the pulse is high is ignored.
- R12: A 4-byte access to an offset (`req_addr[15:0]`) that is not a multiple of 4, or that is above 0x48, reads as 0 and is dropped when written. It raises `unimpl_flag` together with its response for one cycle.
- R13: Address bits above bit 15 do not affect decoding. For example, 0xABCD_0030 reads the clock divider word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address; low 16 bits decoded |
| req_wdata | input | 32 | Write data |
| req_size | input | 4 | Access size in bytes; only 4 accepted |
| cfg_ref_mhz | input | 8 | Static reference clock frequency in MHz |
| cfg_mem_gib | input | 8 | Static installed memory size in GiB |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_rdata | output | 32 | Read data (0 for writes and rejected accesses) |
| sys_reset_pulse | output | 1 | One-cycle system reset request |
| unimpl_flag | output | 1 | Access to an empty offset, aligned with its response |
| cfg_error | output | 1 | Memory size does not fit its 4-bit field |

## Verification
Each output that depends on a request becomes due in the cycle after the rising edge that samples the request: `rsp_valid`, `rsp_rdata`, `unimpl_flag` and `sys_reset_pulse`. This is because each passes through exactly one register. The bench drives requests on falling edges, and its behavioural model computes the expected outputs on the rising edge that samples them. The bench compares the model against the block on the following falling edge, in every cycle. `cfg_error` has no register, so it is checked one nanosecond after its input changes. The read-back checks on read-only words and the back-to-back reset writes are placed so that the ignored stimulus and the read that observes it fall in consecutive response cycles.

// File: rtl/plat_regs_pkg.sv
package plat_regs_pkg;

  localparam int unsigned DATA_W        = 32;
  localparam int unsigned WORD_BYTES    = 4;
  localparam int unsigned NUM_WORDS     = 19;
  localparam int unsigned IDX_W         = $clog2(NUM_WORDS);
  localparam int unsigned FIELD8_W      = 8;
  localparam int unsigned MEM_SIZE_W    = 4;
  localparam int unsigned MEM_MHZ_W     = 12;
  localparam int unsigned RST_REQ_BIT   = 4;

  typedef enum logic [IDX_W-1:0] {
    RG_ID        = 5'd0,
    RG_CORE_REV  = 5'd1,
    RG_SHELL_REV = 5'd2,
    RG_CLK_STAT  = 5'd3,
    RG_RST_CTL   = 5'd4,
    RG_MEM_STAT  = 5'd5,
    RG_LINK_STAT = 5'd6,
    RG_FLASH_CTL = 5'd7,
    RG_SPARE0    = 5'd8,
    RG_SPARE1    = 5'd9,
    RG_SPARE2    = 5'd10,
    RG_SPARE3    = 5'd11,
    RG_CLK_DIV   = 5'd12,
    RG_FEATURE   = 5'd13,
    RG_MEM_CFG   = 5'd14,
    RG_LINK0_WIN = 5'd15,
    RG_LINK1_WIN = 5'd16,
    RG_LINK2_WIN = 5'd17,
    RG_SYS_CTL   = 5'd18
  } word_e;

  localparam logic [DATA_W-1:0] MEM_STAT_VALUE = 32'h0000_0005;
  localparam logic [DATA_W-1:0] FEATURE_VALUE  = 32'h0000_000E;

  function automatic logic [DATA_W-1:0] pack_clk_div(input logic [FIELD8_W-1:0] mhz);
    logic [FIELD8_W-1:0] one;
    one = FIELD8_W'(1);
    return {one, one, mhz, one};
  endfunction

  function automatic logic [DATA_W-1:0] pack_mem_cfg(input logic [MEM_SIZE_W-1:0] gib);
    logic [DATA_W-1:0] v;
    v = '0;
    v[MEM_SIZE_W +: MEM_MHZ_W] = '1;
    v[MEM_SIZE_W-1:0]          = gib;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] word_value(input int unsigned idx,
                                                   input logic [FIELD8_W-1:0] mhz,
                                                   input logic [MEM_SIZE_W-1:0] gib);
    case (idx)
      int'(RG_MEM_STAT): return MEM_STAT_VALUE;
      int'(RG_CLK_DIV):  return pack_clk_div(mhz);
      int'(RG_FEATURE):  return FEATURE_VALUE;
      int'(RG_MEM_CFG):  return pack_mem_cfg(gib);
      default:           return '0;
    endcase
  endfunction

endpackage

// File: rtl/plat_regs_decode.sv
module plat_regs_decode
  import plat_regs_pkg::*;
#(
  parameter int unsigned DEC_W  = 16,
  parameter int unsigned SIZE_W = 4
) (
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [DEC_W-1:0]     offset,
  input  logic                 wdata_rst_bit,
  input  logic [SIZE_W-1:0]    req_size,
  output logic                 acc_go,
  output logic [NUM_WORDS-1:0] word_sel,
  output logic                 unimpl_evt,
  output logic                 rst_req_evt
);

  localparam int unsigned LIMIT = NUM_WORDS * WORD_BYTES;

  logic        aligned;
  logic        in_range;
  logic        known;
  logic [IDX_W-1:0] idx;

  assign acc_go   = req_valid && (req_size == SIZE_W'(WORD_BYTES));
  assign aligned  = (offset[1:0] == 2'b00);
  assign in_range = (32'(offset) < LIMIT);
  assign known    = aligned && in_range;
  assign idx      = offset[IDX_W+1:2];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_sel
    assign word_sel[g] = acc_go && known && (idx == IDX_W'(g));
  end

  assign unimpl_evt  = acc_go && !known;
  assign rst_req_evt = req_write && wdata_rst_bit && word_sel[int'(RG_RST_CTL)];

endmodule

// File: rtl/plat_regs_rdata.sv
module plat_regs_rdata
  import plat_regs_pkg::*;
#(
  parameter int unsigned GIB_W = 8
) (
  input  logic [NUM_WORDS-1:0] word_sel,
  input  logic [FIELD8_W-1:0]  cfg_ref_mhz,
  input  logic [GIB_W-1:0]     cfg_mem_gib,
  output logic [DATA_W-1:0]    rd_value,
  output logic                 cfg_error
);

  logic [DATA_W-1:0] term [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_term
    assign term[g] = word_sel[g] ?
      word_value(g, cfg_ref_mhz, cfg_mem_gib[MEM_SIZE_W-1:0]) : '0;
  end

  always_comb begin
    rd_value = '0;
    for (int i = 0; i < NUM_WORDS; i++) rd_value = rd_value | term[i];
  end

  assign cfg_error = |cfg_mem_gib[GIB_W-1:MEM_SIZE_W];

endmodule

// File: rtl/plat_regs_rstgen.sv
module plat_regs_rstgen (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_req_evt,
  output logic pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= rst_req_evt && !pulse;
  end

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  assert_pulse_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(rst_req_evt));

endmodule

// File: rtl/plat_regs_top.sv
module plat_regs_top
  import plat_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEC_W  = 16,
  parameter int unsigned SIZE_W = 4,
  parameter int unsigned GIB_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [SIZE_W-1:0]   req_size,
  input  logic [FIELD8_W-1:0] cfg_ref_mhz,
  input  logic [GIB_W-1:0]    cfg_mem_gib,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                sys_reset_pulse,
  output logic                unimpl_flag,
  output logic                cfg_error
);

  logic                 acc_go;
  logic [NUM_WORDS-1:0] word_sel;
  logic                 unimpl_evt;
  logic                 rst_req_evt;
  logic [DATA_W-1:0]    rd_value;

  plat_regs_decode #(.DEC_W(DEC_W), .SIZE_W(SIZE_W)) u_decode (
    .req_valid     (req_valid),
    .req_write     (req_write),
    .offset        (req_addr[DEC_W-1:0]),
    .wdata_rst_bit (req_wdata[RST_REQ_BIT]),
    .req_size      (req_size),
    .acc_go        (acc_go),
    .word_sel      (word_sel),
    .unimpl_evt    (unimpl_evt),
    .rst_req_evt   (rst_req_evt)
  );

  plat_regs_rdata #(.GIB_W(GIB_W)) u_rdata (
    .word_sel    (word_sel),
    .cfg_ref_mhz (cfg_ref_mhz),
    .cfg_mem_gib (cfg_mem_gib),
    .rd_value    (rd_value),
    .cfg_error   (cfg_error)
  );

  plat_regs_rstgen u_rstgen (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_req_evt (rst_req_evt),
    .pulse       (sys_reset_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      unimpl_flag <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_rdata   <= (acc_go && !req_write) ? rd_value : '0;
      unimpl_flag <= unimpl_evt;
    end
  end

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_write_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == '0));

  assert_reject_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != SIZE_W'(WORD_BYTES)) |=> (!unimpl_flag && rsp_rdata == '0));

  assert_unimpl_with_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl_flag |-> rsp_valid);

  assert_unimpl_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl_flag |-> (rsp_rdata == '0 && !sys_reset_pulse));

endmodule

// File: tb/plat_regs_top_tb_top.sv
module plat_regs_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_size = 4'd4;
  logic [7:0]  cfg_ref_mhz = 8'd20;
  logic [7:0]  cfg_mem_gib = 8'd1;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        sys_reset_pulse;
  logic        unimpl_flag;
  logic        cfg_error;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  plat_regs_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_size(req_size),
    .cfg_ref_mhz(cfg_ref_mhz), .cfg_mem_gib(cfg_mem_gib),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sys_reset_pulse(sys_reset_pulse), .unimpl_flag(unimpl_flag),
    .cfg_error(cfg_error)
  );

  // behavioural expectation of a read at a 16-bit offset
  function automatic int unsigned model_read(int unsigned off, int unsigned mhz, int unsigned gib);
    if ((off % 4) != 0 || off > 72) return 0;
    if (off == 20) return 5;
    if (off == 48) return 16777216 + 65536 + mhz * 256 + 1;
    if (off == 52) return 14;
    if (off == 56) return 4095 * 16 + (gib % 16);
    return 0;
  endfunction

  function automatic string tag_of(int unsigned off, bit wr, int unsigned sz);
    if (sz != 4) return "R3";
    if (wr) return "R2";
    if ((off % 4) != 0 || off > 72) return "R12";
    if (off == 20) return "R5";
    if (off == 48) return "R6";
    if (off == 52) return "R7";
    if (off == 56) return "R8";
    return "R4";
  endfunction

  // reference model: expected outputs for the cycle after each rising edge
  bit          e_valid, e_pulse, e_unimpl;
  int unsigned e_rdata;
  string       e_tag = "R1";

  always @(posedge clk) begin
    int unsigned off;
    bit ok;
    if (!rst_n) begin
      e_valid <= 0; e_pulse <= 0; e_unimpl <= 0; e_rdata <= 0; e_tag <= "R1";
    end else begin
      off = req_addr % 65536;
      ok  = req_valid && req_size == 4;
      e_valid  <= req_valid;
      e_unimpl <= ok && ((off % 4) != 0 || off > 72);
      e_rdata  <= (ok && !req_write) ? model_read(off, cfg_ref_mhz, cfg_mem_gib) : 0;
      e_pulse  <= ok && req_write && off == 16 && req_wdata[4] && !e_pulse;
      e_tag    <= req_valid ? tag_of(off, req_write, req_size) : "R2";
    end
  end

  task automatic check(string tag, int unsigned act, int unsigned exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      check(rst_n ? "R2" : "R1", rsp_valid, e_valid, "rsp_valid");
      check(rst_n ? e_tag : "R1", rsp_rdata, e_rdata, "rsp_rdata");
      check(rst_n ? "R12" : "R1", unimpl_flag, e_unimpl, "unimpl_flag");
      check(rst_n ? "R10 R11" : "R1", sys_reset_pulse, e_pulse, "sys_reset_pulse");
    end
  end

  task automatic issue(bit wr, logic [31:0] a, logic [31:0] d, logic [3:0] sz);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_size = sz;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 0; req_write = 0;
    end
  endtask

  // directed read: response is on the falling edge after the sampling edge
  task automatic read_chk(logic [31:0] a, logic [31:0] exp, string tag);
    issue(0, a, 0, 4);
    @(negedge clk);
    req_valid = 0;
    check(tag, rsp_rdata, exp, "directed read");
  endtask

  task automatic cfg_chk(logic [7:0] gib, bit exp);
    @(negedge clk);
    cfg_mem_gib = gib;
    #1;
    check("R8", cfg_error, exp, "cfg_error");
  endtask

  initial begin
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1", sys_reset_pulse, 0, "pulse in reset");
    check("R1", rsp_valid, 0, "rsp_valid in reset");
    rst_n = 1;
    idle(1);

    // R4 R5 R6 R7 R8: sweep every listed offset, two configurations
    for (int k = 0; k < 19; k++) issue(0, k * 4, 0, 4);
    idle(1);
    cfg_ref_mhz = 8'd125; cfg_mem_gib = 8'd2;
    idle(1);
    for (int k = 0; k < 19; k++) issue(0, k * 4, 0, 4);
    idle(1);
    read_chk(32'h30, 32'h0101_7D01, "R6");
    read_chk(32'h38, 32'h0000_FFF2, "R8");
    read_chk(32'h14, 32'h5, "R5");
    read_chk(32'h34, 32'hE, "R7");
    read_chk(32'h08, 32'h0, "R4");

    // R13: upper address bits ignored
    read_chk(32'hABCD_0030, 32'h0101_7D01, "R13");
    read_chk(32'hFFFF_0038, 32'h0000_FFF2, "R13");

    // R8: configuration error flag
    cfg_chk(8'd15, 0);
    read_chk(32'h38, 32'h0000_FFFF, "R8");
    cfg_chk(8'd16, 1);
    read_chk(32'h38, 32'h0000_FFF0, "R8");
    cfg_chk(8'd200, 1);
    cfg_chk(8'd1, 0);

    // R3: wrong sizes
    issue(0, 32'h30, 0, 1); issue(0, 32'h30, 0, 2); issue(0, 32'h30, 0, 8);
    issue(0, 32'h31, 0, 2); issue(1, 32'h10, 32'hFFFF_FFFF, 2);
    issue(1, 32'h10, 32'h10, 8);
    idle(2);
    check("R3", sys_reset_pulse, 0, "no pulse from rejected write");

    // R9: writes to read-only words, then read back
    issue(1, 32'h34, 32'hFFFF_FFFF, 4);
    issue(0, 32'h34, 0, 4);
    @(negedge clk); req_valid = 0;
    issue(1, 32'h30, 32'h0, 4);
    issue(1, 32'h38, 32'h0, 4);
    issue(1, 32'h14, 32'h0, 4);
    issue(1, 32'h00, 32'hDEAD_BEEF, 4);
    idle(1);
    read_chk(32'h34, 32'hE, "R9");
    read_chk(32'h30, 32'h0101_7D01, "R9");
    read_chk(32'h38, 32'h0000_FFF1, "R9");
    read_chk(32'h14, 32'h5, "R9");
    read_chk(32'h00, 32'h0, "R9");

    // R10: reset requests
    issue(1, 32'h10, 32'h10, 4);
    @(negedge clk); req_valid = 0;
    check("R10", sys_reset_pulse, 1, "pulse after reset write");
    @(negedge clk);
    check("R10", sys_reset_pulse, 0, "pulse one cycle");
    issue(1, 32'h10, 32'hFFFF_FFEF, 4);
    idle(2);
    check("R10", sys_reset_pulse, 0, "bit 4 clear");

    // R11: back-to-back and triple reset writes
    issue(1, 32'h10, 32'h10, 4);
    issue(1, 32'h10, 32'h10, 4);
    issue(1, 32'h10, 32'h10, 4);
    idle(3);

    // R12: empty offsets
    issue(0, 32'h31, 0, 4); issue(0, 32'h4C, 0, 4); issue(0, 32'hFFC, 0, 4);
    issue(1, 32'h12, 32'h10, 4); issue(0, 32'h0001_FFFC, 0, 4);
    idle(2);
    issue(1, 32'h4E, 32'hFFFF_FFFF, 4);
    @(negedge clk); req_valid = 0;
    check("R12", unimpl_flag, 1, "flag on dropped write");
    check("R12", sys_reset_pulse, 0, "no pulse from dropped write");
    @(negedge clk);
    check("R12", unimpl_flag, 0, "flag one cycle");

    // R1: reset asserted while a reset write is presented
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 32'h10; req_wdata = 32'h10; req_size = 4;
    rst_n = 0;
    @(negedge clk);
    check("R1", sys_reset_pulse, 0, "no pulse during reset");
    req_valid = 0;
    @(negedge clk);
    rst_n = 1;
    idle(3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule